// File: doc/BRIEF.md
# Radix-4 Group-Select Unsigned Multiplier

This block multiplies two 8-bit unsigned operands into a 16-bit product while building only four partial-product rows instead of eight. The second operand is cut into non-overlapping bit pairs, counted up from the least significant end. Each pair becomes a selection code, and the code picks one of four precomputed multiples of the first operand: nothing, once, twice or three times. The tripled multiple comes from adding the single and doubled values once, and all four rows share it.

Each selected row is 10 bits wide. It is weighted by the position of its pair, at offsets of 0, 2, 4 and 6 bits, and the four rows are summed into the product. The pairs do not overlap and the operands are unsigned, so there is no sign extension and no padding bit. A parameter adds an optional output register. With the register present, the product and a valid flag appear one clock after a valid input. Without it, both follow the inputs combinationally.

Top module: `grp2_mult`

## Requirements
- R1: Pair k of operand `b_in` is bits (2k+1, 2k), for k = 0..3, and its two-bit value selects row k: 0 gives an all-zero row, 1 gives `a_in`, 2 gives `a_in` shifted left by one, and 3 gives three times `a_in`.
- R2: Row k is added with a left shift of 2k bits, so that the product equals row0 + row1<<2 + row2<<4 + row3<<6.
- R3: `prod_out` equals `a_in * b_in` for every one of the 65,536 unsigned operand pairs, and never exceeds 65025.
- R4: An operand of zero on either input gives a product of zero.
- R5: When `REG_OUT` = 1, `prod_out` and `vld_out` are registered, and they show the result of the inputs sampled on the rising edge one clock after `vld_in` was high at that edge.
- R6: When `REG_OUT` = 1, a synchronous active-high `rst` clears `vld_out` and `prod_out` to 0 at the next rising edge.
- R7: When `REG_OUT` = 1, a cycle with `vld_in` low leaves `prod_out` holding its last value and drives `vld_out` low.
- R8: When `REG_OUT` = 0, `prod_out` and `vld_out` follow `a_in`, `b_in` and `vld_in` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_in | input | 1 | Operands on `a_in` and `b_in` are valid |
| a_in | input | 8 | Multiplicand |
| b_in | input | 8 | Multiplier; its bit pairs select the rows |
| prod_out | output | 16 | Unsigned product |
| vld_out | output | 1 | Product valid |

## Verification
In the registered build, each product and its valid flag are due exactly one rising edge after the operands are applied. The bench therefore drives the inputs on the falling edge and compares the outputs on the following falling edge, half a period after the capturing edge. The reset and hold checks are sampled the same way, one edge after the stimulus. A second, unregistered instance is checked after a short settling delay in the same cycle the inputs change, and it covers the whole operand space exhaustively.

// File: rtl/grp2_mult.sv
module grp2_mult #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_in,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-1:0] prod_out,
  output logic           vld_out
);
  localparam int NG = W / 2;
  localparam int RW = W + 2;
  localparam int PW = 2 * W;

  logic [RW-1:0] m1, m2, m3;
  logic [RW-1:0] row [NG];
  logic [PW-1:0] acc [NG+1];
  logic [PW-1:0] sum;

  assign m1 = RW'(a_in);
  assign m2 = RW'({a_in, 1'b0});
  assign m3 = m1 + m2;

  assign acc[0] = '0;
  for (genvar k = 0; k < NG; k++) begin : g_row
    logic [1:0] code;
    assign code = b_in[2*k +: 2];
    always_comb begin
      unique case (code)
        2'd0:    row[k] = '0;
        2'd1:    row[k] = m1;
        2'd2:    row[k] = m2;
        default: row[k] = m3;
      endcase
    end
    assign acc[k+1] = acc[k] + (PW'(row[k]) << (2*k));
  end
  assign sum = acc[NG];

  a_r1_row_bound: assert property (@(posedge clk) disable iff (rst)
    row[NG-1] <= RW'(3 * ((1 << W) - 1)));

  a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 || b_in == '0) |-> sum == '0);

  a_r3_range: assert property (@(posedge clk) disable iff (rst)
    sum <= PW'(((1 << W) - 1) * ((1 << W) - 1)));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_out  <= 1'b0;
        prod_out <= '0;
      end else begin
        vld_out <= vld_in;
        if (vld_in) prod_out <= sum;
      end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      vld_in |=> vld_out);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !vld_in |=> (!vld_out && $stable(prod_out)));
  end else begin : g_comb
    assign prod_out = sum;
    assign vld_out  = vld_in;
  end
endmodule

// File: tb/sim_grp2_mult.sv
module sim_grp2_mult;
  logic clk = 1'b0;
  logic rst, vld;
  logic [7:0] a, b;
  logic [15:0] p, pc;
  logic v, vc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  grp2_mult #(.W(8), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .vld_in(vld), .a_in(a), .b_in(b),
    .prod_out(p), .vld_out(v));
  grp2_mult #(.W(8), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .vld_in(vld), .a_in(a), .b_in(b),
    .prod_out(pc), .vld_out(vc));

  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'd0,   8'd0,   16'd0},
    {8'd1,   8'd1,   16'd1},
    {8'd255, 8'd255, 16'd65025},
    {8'd255, 8'd3,   16'd765},
    {8'd7,   8'd2,   16'd14},
    {8'd13,  8'd192, 16'd2496},
    {8'd100, 8'd170, 16'd17000},
    {8'd200, 8'd85,  16'd17000},
    {8'd0,   8'd255, 16'd0},
    {8'd129, 8'd48,  16'd6192}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic vv);
    @(negedge clk);
    a = x; b = y; vld = vv;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; vld = 1'b0; a = 8'd0; b = 8'd0;
    repeat (2) @(negedge clk);
    chk("R6 reset vld", 32'(v), 0);
    chk("R6 reset prod", 32'(p), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:24], VEC[i][23:16], 1'b1);
      @(negedge clk);
      chk("R5 registered valid", 32'(v), 1);
      chk("R3 registered product", 32'(p), 32'(VEC[i][15:0]));
    end

    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++) begin
        apply(8'd201, 8'(c << (2*k)), 1'b1);
        #1;
        chk("R1 R2 row select and weight", 32'(pc), 32'((201 * c) << (2*k)));
      end
    end

    apply(8'd0, 8'd0, 1'b1); #1; chk("R4 zero both", 32'(pc), 0);
    apply(8'd0, 8'd77, 1'b1); #1; chk("R4 zero a", 32'(pc), 0);
    apply(8'd91, 8'd0, 1'b1); #1; chk("R4 zero b", 32'(pc), 0);

    apply(8'd12, 8'd11, 1'b1);
    @(negedge clk);
    chk("R5 product one edge later", 32'(p), 132);
    apply(8'd99, 8'd99, 1'b0);
    @(negedge clk);
    chk("R7 vld low drops valid", 32'(v), 0);
    chk("R7 vld low holds product", 32'(p), 132);

    apply(8'd5, 8'd9, 1'b1);
    #1;
    chk("R8 comb valid same cycle", 32'(vc), 1);
    chk("R8 comb product same cycle", 32'(pc), 45);
    chk("R8 registered not yet updated", 32'(p), 132);
    rst = 1'b1;
    @(negedge clk);
    chk("R6 reset clears valid", 32'(v), 0);
    chk("R6 reset clears product", 32'(p), 0);
    rst = 1'b0;

    begin
      int bad;
      bad = 0;
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          a = 8'(x); b = 8'(y);
          #1;
          if (pc !== 16'(x * y)) begin
            bad++;
            if (bad < 5) $display("FAIL R3 exhaustive %0d*%0d: actual %0d expected %0d", x, y, pc, x * y);
          end
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule